// File: doc/BRIEF.md
# Target Address Compressor with Page Stripping

This block takes a 64-bit target address that has already matched a base address register, together with that register's index and its page size. The page size is given as a power-of-two exponent. The block strips the page base and keeps only the offset within the page. It then streams that offset to the application as one or two 32-bit words. The upper word is sent first and the lower word last.

When the holding feature is enabled, the upper word is left out whenever it equals the upper half of the previously sent offset. The receiving side keeps a mirror of that half so that it can fill in the missing word. The lower word is always sent, so every request carries at least one word. When the feature is off, the number of words follows the page size alone.

A reconstructor inside the same module stands in for the application side. It rebuilds the full page offset from the words it receives and pulses a completion flag when it is done.

Top module: `tgt_addr_squeeze`

## Requirements
- R1: After reset, treq_o, wd_upper_o, wd_last_o and rx_done_o are low and rx_off_o is zero.
- R2: The transmitted offset equals addr_i AND ((1 << pg_exp_i) - 1), for any pg_exp_i from 4 to 63. Address bits at or above the page size never appear in a word.
- R3: With hold_en_i low, a request sends two words when pg_exp_i is greater than 32, and one lower word otherwise.
- R4: With hold_en_i high, the upper word is sent only when bits 63:32 of the new offset differ from bits 63:32 of the previous request's offset. The lower word is always sent, even when the whole offset is unchanged.
- R5: Words appear on consecutive cycles while treq_o is high. An upper word carries wd_upper_o=1 and holds offset bits 63:32. It is followed at once by the lower word, which carries wd_last_o=1 and holds bits 31:0.
- R6: bar_o equals the bar_i value captured with the request, and it stays stable for as long as treq_o is high.
- R7: rx_off_o equals the request's page offset, and rx_done_o pulses for one cycle in the cycle after the last word.
- R8: A req_i pulse that arrives while words are still being sent is ignored. It does not change the words or the result of the transfer in progress.
- R9: The stored previous offset is updated on every accepted request, including requests made with hold_en_i low. An unchanged upper half after any such request is therefore suppressed.
- R10: An accepted request starts its first word in the cycle after the req_i edge. The first word is the upper word when one is needed, otherwise the lower word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, accepted when idle |
| addr_i | input | 64 | Matched target address |
| bar_i | input | 3 | Index of the matching base address register |
| pg_exp_i | input | 6 | Page size exponent, 4 to 63 |
| hold_en_i | input | 1 | Enables suppression of an unchanged upper word |
| treq_o | output | 1 | An address word is valid this cycle |
| wd_upper_o | output | 1 | Current word is the upper half |
| wd_last_o | output | 1 | Current word is the final (lower) word |
| wd_data_o | output | 32 | Address word |
| bar_o | output | 3 | Register index; sample only while treq_o is high |
| rx_off_o | output | 64 | Reconstructed page offset |
| rx_done_o | output | 1 | Reconstruction complete pulse |

## Verification
The assertions assume that hold_en_i is held constant from the accepting req_i edge until rx_done_o. They also assume that pg_exp_i stays within 4 to 63. The bench changes both only between transfers, while the block is idle. It sweeps every exponent with the feature both on and off. The address patterns are chosen to repeat, nudge or flip the upper half, so that both the suppressed and the forced upper-word cases occur for every page size.

// File: rtl/tgt_addr_squeeze.sv
module tgt_addr_squeeze #(
  parameter int AW    = 64,
  parameter int BAR_W = 3,
  parameter int EXP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BAR_W-1:0] bar_i,
  input  logic [EXP_W-1:0] pg_exp_i,
  input  logic             hold_en_i,
  output logic             treq_o,
  output logic             wd_upper_o,
  output logic             wd_last_o,
  output logic [AW/2-1:0]  wd_data_o,
  output logic [BAR_W-1:0] bar_o,
  output logic [AW-1:0]    rx_off_o,
  output logic             rx_done_o
);
  localparam int WW = AW / 2;
  localparam logic [1:0] S_IDLE = 2'd0, S_HI = 2'd1, S_LO = 2'd2;

  logic [1:0]    st;
  logic [AW-1:0] off_q, hold_q;
  logic [WW-1:0] rx_hi;
  logic          rx_got;

  logic [AW-1:0] off_c;
  logic          accept, send_hi;
  logic [WW-1:0] rx_up;

  assign off_c   = addr_i & ~({AW{1'b1}} << pg_exp_i);
  assign accept  = req_i && (st == S_IDLE);
  assign send_hi = hold_en_i ? (off_c[AW-1:WW] != hold_q[AW-1:WW])
                             : (pg_exp_i > EXP_W'(WW));

  assign treq_o     = (st != S_IDLE);
  assign wd_upper_o = (st == S_HI);
  assign wd_last_o  = (st == S_LO);
  assign wd_data_o  = (st == S_HI) ? off_q[AW-1:WW] : off_q[WW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      off_q  <= '0;
      hold_q <= '0;
      bar_o  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          off_q  <= off_c;
          hold_q <= off_c;
          bar_o  <= bar_i;
          st     <= send_hi ? S_HI : S_LO;
        end
        S_HI:    st <= S_LO;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rx_up = (rx_got || hold_en_i) ? rx_hi : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hi     <= '0;
      rx_got    <= 1'b0;
      rx_off_o  <= '0;
      rx_done_o <= 1'b0;
    end else begin
      rx_done_o <= 1'b0;
      if (treq_o && wd_upper_o) begin
        rx_hi  <= wd_data_o;
        rx_got <= 1'b1;
      end else if (treq_o && wd_last_o) begin
        rx_off_o  <= {rx_up, wd_data_o};
        rx_hi     <= rx_up;
        rx_got    <= 1'b0;
        rx_done_o <= 1'b1;
      end
    end
  end
endmodule

module tgt_addr_squeeze_chk #(parameter int BAR_W = 3) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             treq_o,
  input logic             wd_upper_o,
  input logic             wd_last_o,
  input logic             rx_done_o,
  input logic [BAR_W-1:0] bar_o
);
  p_last_not_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    treq_o |-> (wd_upper_o != wd_last_o));
  p_upper_then_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (treq_o && wd_upper_o) |=> (treq_o && wd_last_o));
  p_bar_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (treq_o && !wd_last_o) |=> $stable(bar_o));
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (treq_o && wd_last_o) |=> rx_done_o);
  p_done_only_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_o |-> !treq_o);
  p_busy_ignores_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (treq_o && wd_last_o && req_i) |=> !treq_o);
  p_start_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !treq_o && !rx_done_o) |=> treq_o);
endmodule

bind tgt_addr_squeeze tgt_addr_squeeze_chk #(.BAR_W(BAR_W)) u_chk (.*);

// File: tb/tgt_addr_squeeze_bench.sv
module tgt_addr_squeeze_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_i = 0;
  logic [63:0] addr_i = '0;
  logic [2:0]  bar_i = '0;
  logic [5:0]  pg_exp_i = 6'd4;
  logic        hold_en_i = 0;
  logic        treq_o, wd_upper_o, wd_last_o, rx_done_o;
  logic [31:0] wd_data_o;
  logic [2:0]  bar_o;
  logic [63:0] rx_off_o;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_hold_hi = '0;
  logic [63:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  tgt_addr_squeeze u_tgt_addr_squeeze (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] a, input logic [2:0] b, input logic [5:0] e,
                     input bit en, input bit poke);
    logic [63:0] off;
    int exp_hi, nhi, nwords, guard;
    bit first;
    logic [31:0] up_seen, lo_seen;
    off = a & ~(64'hFFFF_FFFF_FFFF_FFFF << e);
    if (en) exp_hi = (off[63:32] != m_hold_hi) ? 1 : 0;
    else    exp_hi = (e > 6'd32) ? 1 : 0;
    m_hold_hi = off[63:32];
    @(negedge clk);
    addr_i = a; bar_i = b; pg_exp_i = e; hold_en_i = en; req_i = 1;
    @(negedge clk);
    req_i = 0;
    nhi = 0; nwords = 0; guard = 0; first = 1;
    up_seen = '0; lo_seen = '0;
    while (!rx_done_o && guard < 10) begin
      if (treq_o) begin
        if (first) check(wd_upper_o == exp_hi[0], "R10", {63'd0, wd_upper_o}, 64'(exp_hi));
        first = 0;
        check(bar_o == b, "R6", 64'(bar_o), 64'(b));
        nwords++;
        if (wd_upper_o) begin nhi++; up_seen = wd_data_o; end
        if (wd_last_o) lo_seen = wd_data_o;
        if (poke) begin
          addr_i = ~a; bar_i = ~b; req_i = 1;
          poke = 0;
        end
      end
      @(negedge clk);
      req_i = 0;
      guard++;
    end
    check(nhi == exp_hi, en ? "R4" : "R3", 64'(nhi), 64'(exp_hi));
    check(nwords == exp_hi + 1, "R5", 64'(nwords), 64'(exp_hi + 1));
    check(lo_seen == off[31:0], "R2", {32'd0, lo_seen}, {32'd0, off[31:0]});
    if (exp_hi == 1) check(up_seen == off[63:32], "R2", {32'd0, up_seen}, {32'd0, off[63:32]});
    check(rx_done_o && rx_off_o == off, "R7", rx_off_o, off);
    @(negedge clk);
    check(!rx_done_o && !treq_o, "R8", {62'd0, rx_done_o, treq_o}, 64'd0);
    prev_addr = a;
  endtask

  initial begin
    #100000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!treq_o && !wd_upper_o && !wd_last_o && !rx_done_o && rx_off_o == 0, "R1",
          {rx_off_o[59:0], treq_o, wd_upper_o, wd_last_o, rx_done_o}, 64'd0);
    rst_n = 1;
    for (int e = 4; e < 64; e++) begin
      for (int en = 0; en < 2; en++) begin
        for (int k = 0; k < 4; k++) begin
          logic [63:0] a;
          case (k)
            0: a = {$urandom, $urandom};
            1: a = prev_addr + 64'd16;
            2: a = prev_addr;
            default: a = {~prev_addr[63:32], $urandom};
          endcase
          run(a, 3'(e + k), 6'(e), en[0], 1'b0);
        end
      end
    end
    // R9: disabled request with small page clears stored upper half
    run(64'hABCD_1234_0000_0010, 3'd1, 6'd48, 1'b1, 1'b0);
    run(64'hABCD_1234_0000_0020, 3'd2, 6'd20, 1'b0, 1'b0);
    run(64'hABCD_1234_0000_0030, 3'd3, 6'd48, 1'b1, 1'b0);
    run(64'h0000_0000_0000_0040, 3'd4, 6'd20, 1'b1, 1'b0);
    // R8: request pokes during an active transfer
    run(64'h1357_9BDF_2468_ACE0, 3'd5, 6'd63, 1'b0, 1'b1);
    run(64'h1357_9BDF_2468_ACE0, 3'd6, 6'd12, 1'b0, 1'b1);
    run(64'hFFFF_FFFF_FFFF_FFFF, 3'd7, 6'd63, 1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule